// File: doc/BRIEF.md
# Parallel Increment/Decrement Unit

This block adds one to, or takes one from, an unsigned operand of `W` bits without a carry-propagate adder. Each result bit is formed on its own: the operand bit is XORed with the AND of all operand bits below it. Those lower bits are taken as they are for an increment. For a decrement they are inverted first. One shared gate structure serves both directions. Only the inversion of the lower-bit terms is selected by the mode. The logic depth is one wide AND plus one XOR per bit, and the gate count grows roughly with the square of the width.

A wrap flag is raised when an increment passes from all ones to zero, or when a decrement passes from zero to all ones. A registered wrapper captures the result and the flag on a cycle where `in_valid` is high. It presents them on the next cycle with `out_valid`. The wrapper has two named states. `ST_EMPTY` means no result is pending, and `ST_FULL` means a result is being presented. The transition `TAKE` (in_valid high) moves from either state to `ST_FULL`. The transition `DRAIN` (in_valid low) moves from either state to `ST_EMPTY`.

Top module: `unit_stepper`

## Requirements
- R1: With `in_down` = 0 (increment), the presented result equals (operand + 1) modulo 2^W.
- R2: With `in_down` = 1 (decrement), the presented result equals (operand - 1) modulo 2^W.
- R3: Bit 0 of the presented result is always the inverse of bit 0 of the captured operand, in both modes.
- R4: `out_wrap` is 1 exactly when an all-ones operand is incremented or a zero operand is decremented. It is 0 for every other operand and mode.
- R5: `out_valid` is high in the cycle after a cycle where `in_valid` was high, and low in the cycle after a cycle where it was low.
- R6: A cycle with `in_valid` low leaves `out_res` and `out_wrap` unchanged.
- R7: While reset is asserted and until the first accepted input, `out_valid`, `out_res` and `out_wrap` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and mode are taken this cycle |
| in_opnd | input | W | Unsigned operand |
| in_down | input | 1 | Mode: 0 increment, 1 decrement |
| out_valid | output | 1 | Result from the previous cycle's input is presented |
| out_res | output | W | Incremented or decremented value |
| out_wrap | output | 1 | Wrap-around occurred for the presented result |

## Verification
Every result, wrap flag and valid bit is due exactly one rising edge after the input that produced it. The bench drives inputs on the falling edge. It checks the outputs on the following falling edge against the expectation it computed when it drove them. Cycles with `in_valid` low are mixed into the stream. On those cycles the expected result and flag are carried over unchanged and the expected valid is low. Every operand value is sent in both modes, which covers the two wrap corners.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ustep_state_e;
endpackage

// File: rtl/ustep_core.sv
// Parallel +1/-1: each bit is its operand bit XOR the AND of all lower terms.
module ustep_core #(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd,
    input  logic         down,
    output logic [W-1:0] res
);
    localparam int LW = W - 1;

    // lower-bit terms: true bits for increment, inverted bits for decrement
    logic [LW-1:0] lo;
    assign lo = opnd[LW-1:0] ^ {LW{down}};

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign res[0] = ~opnd[0];
        end else begin : g_upper
            assign res[i] = opnd[i] ^ (&lo[i-1:0]);
        end
    end
endmodule

// File: rtl/ustep_wrapdet.sv
// Wrap occurs when every bit is a propagating term: all ones up, all zeros down.
module ustep_wrapdet #(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd,
    input  logic         down,
    output logic         wrap
);
    logic [W-1:0] term;
    assign term = opnd ^ {W{down}};
    assign wrap = &term;
endmodule

// File: rtl/unit_stepper.sv
module unit_stepper
    import ustep_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_opnd,
    input  logic         in_down,
    output logic         out_valid,
    output logic [W-1:0] out_res,
    output logic         out_wrap
);
    ustep_state_e state_q, state_d;
    logic [W-1:0] next_res;
    logic         next_wrap;
    logic [W-1:0] res_q;
    logic         wrap_q;

    ustep_core #(.W(W)) u_core (
        .opnd (in_opnd),
        .down (in_down),
        .res  (next_res)
    );

    ustep_wrapdet #(.W(W)) u_wrap (
        .opnd (in_opnd),
        .down (in_down),
        .wrap (next_wrap)
    );

    // next state: TAKE on in_valid, DRAIN otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // output registers: loaded only on an accepted input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            wrap_q <= 1'b0;
        end else if (in_valid) begin
            res_q  <= next_res;
            wrap_q <= next_wrap;
        end
    end

    assign out_valid = (state_q == ST_FULL);
    assign out_res   = res_q;
    assign out_wrap  = wrap_q;
endmodule

// File: rtl/unit_stepper_chk.sv
module unit_stepper_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] in_opnd,
    input logic         in_down,
    input logic         out_valid,
    input logic [W-1:0] out_res,
    input logic         out_wrap
);
    // R1
    inc_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_down) |=> (out_res == W'($past(in_opnd) + 1'b1)));

    // R2
    dec_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_down) |=> (out_res == W'($past(in_opnd) - 1'b1)));

    // R3
    lsb_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_res[0] == !$past(in_opnd[0])));

    // R4
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_wrap == ($past(in_down) ? ($past(in_opnd) == '0)
                                                  : (&$past(in_opnd)))));

    // R5
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R5
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_res) && $stable(out_wrap)));
endmodule

bind unit_stepper unit_stepper_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_opnd   (in_opnd),
    .in_down   (in_down),
    .out_valid (out_valid),
    .out_res   (out_res),
    .out_wrap  (out_wrap)
);

// File: tb/tb_unit_stepper.sv
module tb_unit_stepper;
    localparam int W = 8;
    localparam int NVAL = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_opnd = '0;
    logic         in_down = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_res;
    logic         out_wrap;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural model state
    logic         exp_valid = 1'b0;
    logic [W-1:0] exp_res = '0;
    logic         exp_wrap = 1'b0;
    logic [W-1:0] last_opnd = '0;

    always #5 clk = ~clk;

    unit_stepper #(.W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_opnd   (in_opnd),
        .in_down   (in_down),
        .out_valid (out_valid),
        .out_res   (out_res),
        .out_wrap  (out_wrap)
    );

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_word(input string tag, input logic [W-1:0] act,
                              input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare outputs against the model, then drive the next cycle
    task automatic step(input bit vld, input logic [W-1:0] op, input bit dn);
        logic [W-1:0] ref_val;
        check_bit("R5 out_valid", out_valid, exp_valid);
        if (exp_valid) begin
            check_word(exp_wrap_mode_tag(), out_res, exp_res);
            check_bit("R3 lsb", out_res[0], ~last_opnd[0]);
            check_bit("R4 out_wrap", out_wrap, exp_wrap);
        end else begin
            check_word("R6 held out_res", out_res, exp_res);
            check_bit("R6 held out_wrap", out_wrap, exp_wrap);
        end
        in_valid = vld;
        in_opnd  = op;
        in_down  = dn;
        exp_valid = vld;
        if (vld) begin
            ref_val   = dn ? op - 1'b1 : op + 1'b1;
            exp_res   = ref_val;
            exp_wrap  = dn ? (op == '0) : (op == {W{1'b1}});
            last_opnd = op;
            cur_down  = dn;
        end
        @(negedge clk);
    endtask

    bit cur_down = 1'b0;
    function automatic string exp_wrap_mode_tag();
        return cur_down ? "R2 decrement" : "R1 increment";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check_bit("R7 reset out_valid", out_valid, 1'b0);
        check_word("R7 reset out_res", out_res, '0);
        check_bit("R7 reset out_wrap", out_wrap, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R7 idle out_valid", out_valid, 1'b0);
        check_word("R7 idle out_res", out_res, '0);
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < NVAL; v++) begin
                step(1'b1, W'(v), m[0]);
                if ((v % 7) == 3) begin
                    // idle cycle with different stimulus on data pins: R6
                    step(1'b0, W'(v + 5), ~m[0]);
                end
            end
        end
        // explicit wrap corners, back to back
        step(1'b1, {W{1'b1}}, 1'b0);
        step(1'b1, '0, 1'b1);
        step(1'b1, '0, 1'b0);
        step(1'b1, {W{1'b1}}, 1'b1);
        step(1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule